// File: doc/BRIEF.md
# Transmit Link Error Status and Reinitialisation Controller

This block gathers single-cycle error events from a transmit link datapath and keeps each one in a sticky status bit. Software clears a status bit by writing 1 to it. Each status bit has its own interrupt enable. The enabled bits are combined into one level-sensitive interrupt line. A small group of error classes can also start an automatic link reinitialisation, each under its own enable. Software can request a reinitialisation by hand through a self-clearing control bit. A read-only flag shows when a reinitialisation is under way.

Access is through a plain 32-bit register port. Writes take effect on the clock edge on which `reg_wr` is high. Reads are combinational from `reg_addr`. The port accepts an access every cycle and never applies back-pressure. The event inputs are also accepted every cycle. The link side sees a request level `reinit_req` and answers with a one-cycle `reinit_done` pulse.

Register word map (byte addresses; bits [1:0] of the address are ignored; any address at or above 0x10 is unmapped):

- 0x0 holds the status bits.
- 0x4 holds the interrupt enables.
- 0x8 holds the reinitialisation enables in bits 3:0.
- 0xC is the control word. Bit 0 is the manual request, which is write-1-to-set. Bit 1 is the in-progress flag, which is read-only.

Status bit positions:

| Bit | Error class |
|---|---|
| 0 | timing reference period mismatch |
| 1 | link-layer input data invalid |
| 2 | transport input data invalid |
| 3 | command stream invalid |
| 4 | lane PLL unlocked |
| 5 | system PLL unlocked |
| 6 | reset-sequencer alarm |
| 7 | gearbox underflow |
| 8 | gearbox overflow |
| 9 | reserved |
| 10 | elastic FIFO overflow |

Top module: `tx_err_ctrl`

## Requirements
- R1: After reset the registers hold these values. Status reads 0x000 and the reinitialisation enables read 0x0. The interrupt enables read 0x5F1, which has bits 0, 4 to 8 and 10 set. The control word reads 0. Both `irq` and `reinit_req` are low.
- R2: A pulse on `evt[i]` sets status bit i. The bit reads 1 from the cycle after the pulse and stays set while further events arrive.
- R3: A write to 0x0 clears each status bit whose data bit is 1. Status bits whose data bit is 0 are unchanged.
- R4: If an event and a write-1-to-clear of the same status bit fall in the same cycle, the bit stays set.
- R5: `irq` is high exactly when some status bit and its interrupt enable are both 1. It follows status and enable changes one cycle after the event or write. It stays high until the status is cleared or the enable is cleared.
- R6: An event on bit i (0 to 3) starts an automatic reinitialisation when all of these hold: status bit i was 0, reinitialisation enable bit i is 1, and the controller is idle. In that case `reinit_req` is high from the cycle after the event. Events on bits 4 to 10 never start one. An event on an already-set bit does not start one.
- R7: `reinit_req` stays high until a `reinit_done` pulse and goes low in the cycle after it. Control bit 1 reads 1 exactly while `reinit_req` is high.
- R8: Writing 1 to control bit 0 makes that bit read 1 in the next cycle. `reinit_req` rises one cycle after that, and control bit 0 then reads 0. Writing 0 to control bit 0 has no effect.
- R9: A manual request written while a reinitialisation is in progress stays pending. After `reinit_done`, `reinit_req` is low for one cycle and then rises again.
- R10: Status bit 9, status and enable bits 11 to 31, and reinitialisation-enable bits 4 to 31 read 0. These bits ignore writes and events. Unmapped addresses read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (6) | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| evt | input | EVT_W (11) | Error event pulses, one bit per class |
| irq | output | 1 | Level interrupt |
| reinit_req | output | 1 | Link reinitialisation request level |
| reinit_done | input | 1 | One-cycle pulse: reinitialisation finished |

## Verification
The bench targets these corner cases:

- An event and a clear that collide on one bit. A design that gives the clear priority would lose the error.
- A second event on an already-set bit that has a reinitialisation enable. A design that triggers on the level instead of the new edge would restart the link forever.
- A manual request written while a reinitialisation is busy. A design that drops it, or merges it into the running one, would never raise the request a second time.
- Writes of all ones and events on the reserved position. These expose any reserved bit that stores a value, and any write to an unmapped address that aliases onto a real register.

// File: rtl/tx_err_pkg.sv
package tx_err_pkg;
  // word select taken from address bits [3:2]
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_IEN    = 2'd1,
    SEL_REN    = 2'd2,
    SEL_CTRL   = 2'd3
  } reg_sel_e;

  localparam int unsigned CTRL_MAN_BIT  = 0;
  localparam int unsigned CTRL_BUSY_BIT = 1;

  typedef enum logic {
    RI_IDLE = 1'b0,
    RI_BUSY = 1'b1
  } ri_state_e;
endpackage

// File: rtl/err_status_bank.sv
module err_status_bank #(
  parameter int unsigned W = 11,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] fresh_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL_MASK[i]) begin : g_impl
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        st_q <= 1'b0;
        else if (evt_i[i]) st_q <= 1'b1;   // event beats a same-cycle clear
        else if (clr_i[i]) st_q <= 1'b0;
      end
      assign status_o[i] = st_q;
      assign fresh_o[i]  = evt_i[i] & ~st_q;
    end else begin : g_rsvd
      assign status_o[i] = 1'b0;
      assign fresh_o[i]  = 1'b0;
    end
  end
endmodule

// File: rtl/err_mask_reg.sv
module err_mask_reg #(
  parameter int unsigned W = 11,
  parameter logic [W-1:0] RESET_VAL = '0,
  parameter logic [W-1:0] IMPL_MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= RESET_VAL & IMPL_MASK;
    else if (we_i) q <= wdata_i & IMPL_MASK;
  end
  assign q_o = q;
endmodule

// File: rtl/reinit_seq.sv
module reinit_seq
  import tx_err_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic auto_trig_i,
  input  logic man_set_i,
  input  logic done_i,
  output logic req_o,
  output logic man_pend_o
);
  ri_state_e state_q;
  logic      man_q;
  logic      take;

  assign take = (state_q == RI_IDLE) && (auto_trig_i || man_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RI_IDLE;
      man_q   <= 1'b0;
    end else begin
      man_q <= man_set_i | (man_q & ~take);
      case (state_q)
        RI_IDLE: if (take)   state_q <= RI_BUSY;
        RI_BUSY: if (done_i) state_q <= RI_IDLE;
        default:             state_q <= RI_IDLE;
      endcase
    end
  end

  assign req_o      = (state_q == RI_BUSY);
  assign man_pend_o = man_q;
endmodule

// File: rtl/tx_err_ctrl.sv
module tx_err_ctrl
  import tx_err_pkg::*;
#(
  parameter int unsigned EVT_W        = 11,
  parameter int unsigned REINIT_W     = 4,
  parameter int unsigned ADDR_W       = 6,
  parameter logic [EVT_W-1:0] IMPL_MASK = 11'h5FF,
  parameter logic [EVT_W-1:0] IEN_RESET = 11'h5F1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [EVT_W-1:0]  evt,
  output logic              irq,
  output logic              reinit_req,
  input  logic              reinit_done
);
  localparam int unsigned MAP_TOP = 4;  // first unmapped byte-address bit

  logic          hit;
  reg_sel_e      sel;
  logic [EVT_W-1:0]    status_q, fresh, ien_q, clr;
  logic [REINIT_W-1:0] ren_q;
  logic          man_pend, man_set;

  assign hit = (reg_addr >> MAP_TOP) == '0;
  assign sel = reg_sel_e'(reg_addr[3:2]);

  assign clr     = (reg_wr && hit && sel == SEL_STATUS) ? reg_wdata[EVT_W-1:0] : '0;
  assign man_set = reg_wr && hit && sel == SEL_CTRL && reg_wdata[CTRL_MAN_BIT];

  err_status_bank #(.W(EVT_W), .IMPL_MASK(IMPL_MASK)) u_status (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .clr_i(clr),
    .status_o(status_q), .fresh_o(fresh)
  );

  err_mask_reg #(.W(EVT_W), .RESET_VAL(IEN_RESET), .IMPL_MASK(IMPL_MASK)) u_ien (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_wr && hit && sel == SEL_IEN),
    .wdata_i(reg_wdata[EVT_W-1:0]), .q_o(ien_q)
  );

  err_mask_reg #(.W(REINIT_W), .RESET_VAL('0), .IMPL_MASK('1)) u_ren (
    .clk(clk), .rst_n(rst_n),
    .we_i(reg_wr && hit && sel == SEL_REN),
    .wdata_i(reg_wdata[REINIT_W-1:0]), .q_o(ren_q)
  );

  reinit_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .auto_trig_i(|(fresh[REINIT_W-1:0] & ren_q)),
    .man_set_i(man_set), .done_i(reinit_done),
    .req_o(reinit_req), .man_pend_o(man_pend)
  );

  assign irq = |(status_q & ien_q);

  always_comb begin
    reg_rdata = '0;
    if (hit) begin
      case (sel)
        SEL_STATUS: reg_rdata[EVT_W-1:0]    = status_q;
        SEL_IEN:    reg_rdata[EVT_W-1:0]    = ien_q;
        SEL_REN:    reg_rdata[REINIT_W-1:0] = ren_q;
        SEL_CTRL: begin
          reg_rdata[CTRL_MAN_BIT]  = man_pend;
          reg_rdata[CTRL_BUSY_BIT] = reinit_req;
        end
        default: reg_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/tx_err_ctrl_chk.sv
module tx_err_ctrl_chk #(
  parameter int unsigned EVT_W  = 11,
  parameter int unsigned ADDR_W = 6,
  parameter logic [EVT_W-1:0] IMPL_MASK = 11'h5FF
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr,
  input logic [31:0]       reg_wdata,
  input logic [EVT_W-1:0]  evt,
  input logic [EVT_W-1:0]  status_q,
  input logic              irq,
  input logic              reinit_req,
  input logic              reinit_done
);
  logic wr_status;
  assign wr_status = reg_wr && (reg_addr == '0);

  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    |(evt & IMPL_MASK) |=> ((status_q & $past(evt & IMPL_MASK)) == $past(evt & IMPL_MASK))); // R2

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_status |=> ((status_q & $past(reg_wdata[EVT_W-1:0] & ~evt)) == '0)); // R3

  AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !reg_wr) |=> irq); // R5

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit_req && !reinit_done) |=> reinit_req); // R7

  AST_REQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reinit_req && reinit_done) |=> !reinit_req); // R7
endmodule

bind tx_err_ctrl tx_err_ctrl_chk #(.EVT_W(EVT_W), .ADDR_W(ADDR_W), .IMPL_MASK(IMPL_MASK)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
  .reg_wdata(reg_wdata), .evt(evt), .status_q(status_q), .irq(irq),
  .reinit_req(reinit_req), .reinit_done(reinit_done)
);

// File: tb/tx_err_ctrl_tb_top.sv
module tx_err_ctrl_tb_top;
  localparam logic [5:0] A_ST = 6'h00, A_IEN = 6'h04, A_REN = 6'h08, A_CTL = 6'h0C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [10:0] evt = '0;
  logic        irq, reinit_req;
  logic        reinit_done = 1'b0;
  int          n_chk = 0, n_bad = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  tx_err_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt(evt), .irq(irq),
    .reinit_req(reinit_req), .reinit_done(reinit_done)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    check(req, reg_rdata, exp);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic done_pulse();
    @(negedge clk);
    reinit_done = 1'b1;
    @(negedge clk);
    reinit_done = 1'b0;
  endtask

  task automatic t_reset();
    rd_chk("R1 status", A_ST, 32'h0);
    rd_chk("R1 ien", A_IEN, 32'h5F1);
    rd_chk("R1 ren", A_REN, 32'h0);
    rd_chk("R1 ctrl", A_CTL, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 req", {31'b0, reinit_req}, 32'h0);
  endtask

  task automatic t_sticky();
    pulse(11'h020);
    @(negedge clk);
    rd_chk("R2 held", A_ST, 32'h020);
    pulse(11'h080);
    rd_chk("R2 accum", A_ST, 32'h0A0);
  endtask

  task automatic t_w1c();
    wr(A_ST, 32'h020);
    rd_chk("R3 clear one", A_ST, 32'h080);
    wr(A_ST, 32'h000);
    rd_chk("R3 zero no effect", A_ST, 32'h080);
    wr(A_ST, 32'hFFFF_FFFF);
    rd_chk("R3 clear all", A_ST, 32'h000);
  endtask

  task automatic t_collide();
    pulse(11'h004);
    @(negedge clk);
    reg_addr = A_ST; reg_wdata = 32'h4; reg_wr = 1'b1; evt = 11'h004;
    @(negedge clk);
    reg_wr = 1'b0; evt = '0;
    rd_chk("R4 event wins", A_ST, 32'h004);
    wr(A_ST, 32'h4);
    rd_chk("R4 later clear", A_ST, 32'h000);
  endtask

  task automatic t_irq();
    pulse(11'h002);
    check("R5 disabled bit", {31'b0, irq}, 32'h0);
    pulse(11'h010);
    check("R5 enabled bit", {31'b0, irq}, 32'h1);
    wr(A_IEN, 32'h0);
    check("R5 enable off", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h2);
    check("R5 enable other", {31'b0, irq}, 32'h1);
    wr(A_ST, 32'h012);
    check("R5 cleared", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h5F1);
  endtask

  task automatic t_auto();
    wr(A_REN, 32'h1);
    pulse(11'h040);
    check("R6 high bit no start", {31'b0, reinit_req}, 32'h0);
    pulse(11'h002);
    check("R6 ren off no start", {31'b0, reinit_req}, 32'h0);
    wr(A_ST, 32'h042);
    pulse(11'h001);
    check("R6 start", {31'b0, reinit_req}, 32'h1);
    rd_chk("R7 busy flag", A_CTL, 32'h2);
    repeat (3) @(negedge clk);
    check("R7 hold", {31'b0, reinit_req}, 32'h1);
    done_pulse();
    check("R7 drop", {31'b0, reinit_req}, 32'h0);
    rd_chk("R7 flag clear", A_CTL, 32'h0);
    pulse(11'h001);
    check("R6 no retrigger", {31'b0, reinit_req}, 32'h0);
    wr(A_ST, 32'h1);
    wr(A_REN, 32'h0);
  endtask

  task automatic t_manual();
    wr(A_CTL, 32'h0);
    rd_chk("R8 zero write", A_CTL, 32'h0);
    wr(A_CTL, 32'h1);
    rd_chk("R8 pending", A_CTL, 32'h1);
    check("R8 not yet", {31'b0, reinit_req}, 32'h0);
    @(negedge clk);
    check("R8 started", {31'b0, reinit_req}, 32'h1);
    rd_chk("R8 self clear", A_CTL, 32'h2);
    done_pulse();
  endtask

  task automatic t_queue();
    wr(A_CTL, 32'h1);
    @(negedge clk);
    wr(A_CTL, 32'h1);
    rd_chk("R9 queued", A_CTL, 32'h3);
    done_pulse();
    check("R9 gap", {31'b0, reinit_req}, 32'h0);
    @(negedge clk);
    check("R9 restart", {31'b0, reinit_req}, 32'h1);
    rd_chk("R9 taken", A_CTL, 32'h2);
    done_pulse();
  endtask

  task automatic t_reserved();
    wr(A_IEN, 32'hFFFF_FFFF);
    rd_chk("R10 ien mask", A_IEN, 32'h5FF);
    wr(A_REN, 32'hFFFF_FFFF);
    rd_chk("R10 ren mask", A_REN, 32'hF);
    wr(A_REN, 32'h0);
    wr(A_IEN, 32'h5F1);
    pulse(11'h200);
    rd_chk("R10 bit9 event", A_ST, 32'h0);
    rd_chk("R10 unmapped read", 6'h24, 32'h0);
    wr(6'h24, 32'h0);
    rd_chk("R10 unmapped write", A_IEN, 32'h5F1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_sticky();
    t_w1c();
    t_collide();
    t_irq();
    t_auto();
    t_manual();
    t_queue();
    t_reserved();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule